// File: doc/BRIEF.md
# Time-of-Day Counter with Coherent Read Latch

This peripheral keeps wall-clock time as tenths of a second, seconds, minutes and a 12-hour hour count, all in packed BCD. It advances once for each pulse on a tenths tick input. Software reaches it over a small register bus made of a chip select, an address, read and write strobes and 8-bit data. Only the low four address bits are decoded, so the four time registers repeat across the whole address range that the chip select covers.

Reading a multi-digit time one byte at a time can tear when a carry lands between two reads. The block prevents this with a read latch. A read of the hours register takes a snapshot of the full time and freezes what later reads return. A read of the tenths register returns the frozen tenths and then releases the latch. The live counters keep running the whole time, so the first live read after release shows the time that passed while the latch was held. Writes load the time. A write to hours stops the count and a write to tenths starts it again, so software can load a consistent value.

There are two state machines. The run machine has states `RUN_ON` and `RUN_HALT`. It takes transition *halt* (`RUN_ON` to `RUN_HALT`) on an hours write and transition *resume* (`RUN_HALT` to `RUN_ON`) on a tenths write. The latch machine has states `LATCH_LIVE` and `LATCH_FROZEN`. It takes transition *engage* (`LATCH_LIVE` to `LATCH_FROZEN`) on an hours read and transition *release* (`LATCH_FROZEN` to `LATCH_LIVE`) on a tenths read. Every other event leaves a machine in its current state.

Top module: `tod_clock_top`

## Requirements
- R1: A synchronous reset sets the time to 12:00:00.0 with the PM flag clear, puts the run machine in the running state, releases the latch and clears the read data.
- R2: The tenths register counts 0 to 9 in bits 3:0, one step per tick, and carries into seconds. Seconds and minutes count 00 to 59 in packed BCD (tens digit in bits 6:4, ones digit in bits 3:0), and each carries into the next field when it wraps.
- R3: The hours register holds 01 to 12 in BCD in bits 4:0, with bit 7 as the PM flag. Going from 11 to 12 toggles PM. Going from 12 to 01 leaves PM unchanged. Bits 6:5 read as zero.
- R4: Register index = address bits 3:0. Index 8 is tenths, 9 is seconds, 10 is minutes and 11 is hours. Higher address bits are ignored. The read data appears on the output at the clock edge that samples chip select together with the read strobe, and it holds until the next read.
- R5: A read of any other index returns 0x00. Bits 7:4 of tenths and bit 7 of seconds and minutes read as zero.
- R6: In the live state, an hours read captures the whole time at that edge and engages the latch. While the latch is engaged, reads of hours, minutes and seconds return the snapshot. A repeated hours read does not capture again.
- R7: A tenths read while the latch is engaged returns the snapshot tenths. The latch releases after that read, and later reads return live values.
- R8: The counters keep advancing while the latch is engaged. After release, reads show all ticks that arrived in the meantime.
- R9: If hours is never read, every read returns the live value.
- R10: A write to any of the four indices loads that field. An hours write halts counting, so ticks have no effect. A tenths write restarts counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle pulse per tenth of a second |
| cs_i | input | 1 | Chip select |
| addr_i | input | ADDR_W (8) | Address; only bits 3:0 decoded |
| rd_i | input | 1 | Read strobe, qualified by cs_i |
| wr_i | input | 1 | Write strobe, qualified by cs_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
A read drives chip select and the read strobe for one cycle. The value, along with any latch engage or release, is registered at that same rising edge. The bench drives inputs on the falling edge and samples `rdata_o` on the next falling edge, half a cycle after the value settles. A tick is registered at the edge that samples it, so a read issued one cycle later already shows the new count. Writes take effect at their own edge, and the run state changes at that edge too. For this reason the bench model updates its expected time and run flag as each write is issued. It advances the expected time only on ticks that arrive while the model is running.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int IDX_W = 4;

    localparam logic [IDX_W-1:0] IDX_TENTHS = 4'h8;
    localparam logic [IDX_W-1:0] IDX_SEC    = 4'h9;
    localparam logic [IDX_W-1:0] IDX_MIN    = 4'hA;
    localparam logic [IDX_W-1:0] IDX_HR     = 4'hB;

    typedef struct packed {
        logic       pm;
        logic [4:0] hr;
        logic [6:0] mn;
        logic [6:0] sc;
        logic [3:0] te;
    } tod_time_t;

    localparam tod_time_t TOD_RESET = '{pm: 1'b0, hr: 5'h12, mn: 7'h00, sc: 7'h00, te: 4'h0};

    typedef enum logic {RUN_ON, RUN_HALT} run_state_t;
    typedef enum logic {LATCH_LIVE, LATCH_FROZEN} latch_state_t;
    typedef enum logic [2:0] {SEL_NONE, SEL_TE, SEL_SC, SEL_MN, SEL_HR} reg_sel_t;

    function automatic reg_sel_t decode_idx(input logic [IDX_W-1:0] idx);
        reg_sel_t s;
        unique case (idx)
            IDX_TENTHS: s = SEL_TE;
            IDX_SEC:    s = SEL_SC;
            IDX_MIN:    s = SEL_MN;
            IDX_HR:     s = SEL_HR;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tod_bcd_wrap.sv
module tod_bcd_wrap #(
    parameter int TENS_W   = 3,
    parameter int TENS_MAX = 5
) (
    input  logic [TENS_W+3:0] val_i,
    output logic [TENS_W+3:0] next_o,
    output logic              wrap_o
);
    localparam logic [TENS_W-1:0] TOP_TENS = TENS_W'(TENS_MAX);

    logic [3:0]        ones;
    logic [TENS_W-1:0] tens;

    assign ones = val_i[3:0];
    assign tens = val_i[TENS_W+3:4];

    always_comb begin
        wrap_o = (ones == 4'd9) && (tens == TOP_TENS);
        if (ones != 4'd9)
            next_o = {tens, ones + 4'd1};
        else if (wrap_o)
            next_o = '0;
        else
            next_o = {tens + 1'b1, 4'd0};
    end
endmodule

// File: rtl/tod_hour_step.sv
module tod_hour_step (
    input  logic       pm_i,
    input  logic [4:0] hr_i,
    output logic       pm_o,
    output logic [4:0] hr_o
);
    always_comb begin
        pm_o = pm_i;
        if (hr_i == 5'h12) begin
            hr_o = 5'h01;
        end else if (hr_i == 5'h11) begin
            hr_o = 5'h12;
            pm_o = ~pm_i;
        end else if (hr_i[3:0] == 4'd9) begin
            hr_o = 5'h10;
        end else begin
            hr_o = {hr_i[4], hr_i[3:0] + 4'd1};
        end
    end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_i,
    input  reg_sel_t  wr_sel_i,
    input  logic [7:0] wdata_i,
    output tod_time_t time_o,
    output logic      running_o
);
    localparam int SM_TENS_W = 3;
    localparam int SM_W      = SM_TENS_W + 4;

    run_state_t state_q, state_d;
    tod_time_t  time_q, stepped;

    logic            te_wrap;
    logic [SM_W-1:0] sc_next, mn_next;
    logic            sc_wrap, mn_wrap;
    logic            hr_pm_next;
    logic [4:0]      hr_next;

    // seconds and minutes share the same 00..59 digit pair
    tod_bcd_wrap #(.TENS_W(SM_TENS_W), .TENS_MAX(5)) u_sec (
        .val_i (time_q.sc),
        .next_o(sc_next),
        .wrap_o(sc_wrap)
    );

    tod_bcd_wrap #(.TENS_W(SM_TENS_W), .TENS_MAX(5)) u_min (
        .val_i (time_q.mn),
        .next_o(mn_next),
        .wrap_o(mn_wrap)
    );

    tod_hour_step u_hour (
        .pm_i(time_q.pm),
        .hr_i(time_q.hr),
        .pm_o(hr_pm_next),
        .hr_o(hr_next)
    );

    assign te_wrap = (time_q.te == 4'd9);

    always_comb begin
        stepped    = time_q;
        stepped.te = te_wrap ? 4'd0 : time_q.te + 4'd1;
        if (te_wrap) begin
            stepped.sc = sc_next;
            if (sc_wrap) begin
                stepped.mn = mn_next;
                if (mn_wrap) begin
                    stepped.hr = hr_next;
                    stepped.pm = hr_pm_next;
                end
            end
        end
    end

    // run machine: state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= RUN_ON;
        else     state_q <= state_d;
    end

    // run machine: transitions (halt, resume)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_ON:   if (wr_sel_i == SEL_HR) state_d = RUN_HALT;
            RUN_HALT: if (wr_sel_i == SEL_TE) state_d = RUN_ON;
            default:  state_d = RUN_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= TOD_RESET;
        end else begin
            unique case (wr_sel_i)
                SEL_TE: time_q.te <= wdata_i[3:0];
                SEL_SC: time_q.sc <= wdata_i[6:0];
                SEL_MN: time_q.mn <= wdata_i[6:0];
                SEL_HR: begin
                    time_q.hr <= wdata_i[4:0];
                    time_q.pm <= wdata_i[7];
                end
                default: if (state_q == RUN_ON && tick_i) time_q <= stepped;
            endcase
        end
    end

    assign time_o    = time_q;
    assign running_o = (state_q == RUN_ON);

    AST_TENTHS_WRAP: assert property (@(posedge clk) disable iff (rst)
        (running_o && tick_i && wr_sel_i == SEL_NONE && time_q.te == 4'd9) |=> (time_q.te == 4'd0)) // R2
        else $error("tenths did not wrap");

    AST_TENTHS_STEP: assert property (@(posedge clk) disable iff (rst)
        (running_o && tick_i && wr_sel_i == SEL_NONE && time_q.te < 4'd9) |=> (time_q.te == $past(time_q.te) + 4'd1)) // R2
        else $error("tenths did not step");

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!running_o && wr_sel_i == SEL_NONE) |=> $stable(time_q)) // R10
        else $error("time moved while halted");

    AST_HOUR_HALTS: assert property (@(posedge clk) disable iff (rst)
        (wr_sel_i == SEL_HR) |=> !running_o) // R10
        else $error("hours write did not halt");

endmodule

// File: rtl/tod_latch.sv
module tod_latch
    import tod_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tod_time_t live_i,
    input  reg_sel_t  rd_sel_i,
    output tod_time_t view_o,
    output logic      frozen_o
);
    latch_state_t state_q, state_d;
    tod_time_t    snap_q;

    // latch machine: state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= LATCH_LIVE;
        else     state_q <= state_d;
    end

    // latch machine: transitions (engage, release)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LATCH_LIVE:   if (rd_sel_i == SEL_HR) state_d = LATCH_FROZEN;
            LATCH_FROZEN: if (rd_sel_i == SEL_TE) state_d = LATCH_LIVE;
            default:      state_d = LATCH_LIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= TOD_RESET;
        else if (state_q == LATCH_LIVE && rd_sel_i == SEL_HR)
            snap_q <= live_i;
    end

    // outputs
    always_comb begin
        frozen_o = (state_q == LATCH_FROZEN);
        view_o   = frozen_o ? snap_q : live_i;
    end

    AST_ENGAGE: assert property (@(posedge clk) disable iff (rst)
        (rd_sel_i == SEL_HR) |=> frozen_o) // R6
        else $error("hours read did not engage latch");

    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (frozen_o && rd_sel_i == SEL_TE) |=> !frozen_o) // R7
        else $error("tenths read did not release latch");

    AST_STAY_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (frozen_o && rd_sel_i != SEL_TE) |=> (frozen_o && $stable(view_o))) // R6
        else $error("frozen view changed");

endmodule

// File: rtl/tod_clock_top.sv
module tod_clock_top
    import tod_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              cs_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o
);
    logic       rd_fire, wr_fire;
    reg_sel_t   idx_sel, rd_sel, wr_sel;
    tod_time_t  live, view;
    logic       running, frozen;
    logic [7:0] rd_byte, rdata_q;

    assign rd_fire = cs_i && rd_i;
    assign wr_fire = cs_i && wr_i;
    assign idx_sel = decode_idx(addr_i[IDX_W-1:0]);
    assign rd_sel  = rd_fire ? idx_sel : SEL_NONE;
    assign wr_sel  = wr_fire ? idx_sel : SEL_NONE;

    tod_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .wr_sel_i (wr_sel),
        .wdata_i  (wdata_i),
        .time_o   (live),
        .running_o(running)
    );

    tod_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .live_i  (live),
        .rd_sel_i(rd_sel),
        .view_o  (view),
        .frozen_o(frozen)
    );

    always_comb begin
        unique case (idx_sel)
            SEL_TE:  rd_byte = {4'b0, view.te};
            SEL_SC:  rd_byte = {1'b0, view.sc};
            SEL_MN:  rd_byte = {1'b0, view.mn};
            SEL_HR:  rd_byte = {view.pm, 2'b0, view.hr};
            default: rd_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata_q <= 8'h00;
        else if (rd_fire) rdata_q <= rd_byte;
    end

    assign rdata_o = rdata_q;

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && idx_sel == SEL_NONE) |=> (rdata_o == 8'h00)) // R5
        else $error("unused index returned data");

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_fire |=> $stable(rdata_o)) // R4
        else $error("read data changed without a read");

    AST_HOUR_PAD: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && idx_sel == SEL_HR) |=> (rdata_o[6:5] == 2'b00)) // R3
        else $error("hours pad bits set");

endmodule

// File: tb/sim_tod_clock_top.sv
module sim_tod_clock_top;
    localparam int DAY = 864000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       cs_i = 1'b0;
    logic [7:0] addr_i = 8'h00;
    logic       rd_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;

    int n_run = 0;
    int n_fail = 0;
    int t = 0;
    bit running = 1'b1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tod_clock_top #(.ADDR_W(8)) u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i), .cs_i(cs_i), .addr_i(addr_i),
        .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
    );

    function automatic logic [7:0] to_bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int compose(input int pm, input int h, input int m, input int s, input int te);
        return pm * 432000 + (h % 12) * 36000 + m * 600 + s * 10 + te;
    endfunction

    // expected byte at low index lo for a time given in tenths since 12:00:00.0 AM
    function automatic logic [7:0] fmt(input int tt, input int lo);
        int hc;
        hc = (tt / 36000) % 12;
        case (lo)
            8:  return to_bcd(tt % 10);
            9:  return to_bcd((tt / 10) % 60);
            10: return to_bcd((tt / 600) % 60);
            11: return {((tt / 432000) % 2 == 1), 2'b00, to_bcd(hc == 0 ? 12 : hc)[4:0]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_i = 1'b1; rd_i = 1'b1; addr_i = a;
        @(negedge clk);
        cs_i = 1'b0; rd_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        int pm, h, m, s, te, hc;
        @(negedge clk);
        cs_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        cs_i = 1'b0; wr_i = 1'b0;
        te = t % 10; s = (t / 10) % 60; m = (t / 600) % 60;
        hc = (t / 36000) % 12; h = (hc == 0) ? 12 : hc; pm = (t / 432000) % 2;
        case (a[3:0])
            4'h8: begin te = from_bcd({4'b0, d[3:0]}); running = 1'b1; end
            4'h9: s = from_bcd({1'b0, d[6:0]});
            4'hA: m = from_bcd({1'b0, d[6:0]});
            4'hB: begin h = from_bcd({3'b0, d[4:0]}); pm = int'(d[7]); running = 1'b0; end
            default: ;
        endcase
        t = compose(pm, h, m, s, te);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
            if (running) t = (t + 1) % DAY;
        end
    endtask

    task automatic load(input int pm, input int h, input int m, input int s, input int te);
        wr(8'h0B, {pm[0], 2'b00, to_bcd(h)[4:0]});
        wr(8'h0A, to_bcd(m));
        wr(8'h09, to_bcd(s));
        wr(8'h08, to_bcd(te));
    endtask

    // coherent read of all four registers through the latch
    task automatic read_all(input string tag);
        logic [7:0] d;
        int tt;
        tt = t;
        rd(8'h0B, d); chk({tag, " hours"}, d, fmt(tt, 11));
        rd(8'h0A, d); chk({tag, " minutes"}, d, fmt(tt, 10));
        rd(8'h09, d); chk({tag, " seconds"}, d, fmt(tt, 9));
        rd(8'h08, d); chk({tag, " tenths"}, d, fmt(tt, 8));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int t0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, R9 live reads without hours read
        chk("R1 rdata after reset", rdata_o, 8'h00);
        rd(8'h0A, d); chk("R1 minutes", d, 8'h00);
        rd(8'h09, d); chk("R1 seconds", d, 8'h00);
        rd(8'h0B, d); chk("R1 hours", d, 8'h12);
        rd(8'h08, d); chk("R1 tenths", d, 8'h00);

        // R10 load and R4/R5 mirrored decode over all 256 addresses
        load(1, 7, 34, 56, 3);
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), d);
            chk("R4 R5 mirrored decode", d, fmt(t, a % 16));
        end
        rd(8'h08, d);

        // R2 R9 live counting across a minute carry, no hours read
        for (int i = 0; i < 700; i++) begin
            ticks(1);
            rd(8'h58, d); chk("R2 R9 live tenths", d, fmt(t, 8));
            rd(8'hE9, d); chk("R2 R9 live seconds", d, fmt(t, 9));
            rd(8'h3A, d); chk("R2 R9 live minutes", d, fmt(t, 10));
        end

        // R6 R7 R8 latch freeze, hold, release and jump forward
        load(0, 3, 59, 58, 7);
        t0 = t;
        rd(8'h7B, d); chk("R6 engage hours", d, fmt(t0, 11));
        ticks(137);
        rd(8'h0A, d); chk("R6 frozen minutes", d, fmt(t0, 10));
        rd(8'h09, d); chk("R6 frozen seconds", d, fmt(t0, 9));
        rd(8'h0B, d); chk("R6 repeat hours", d, fmt(t0, 11));
        ticks(700);
        rd(8'h1A, d); chk("R6 no recapture minutes", d, fmt(t0, 10));
        rd(8'h19, d); chk("R6 no recapture seconds", d, fmt(t0, 9));
        rd(8'hC8, d); chk("R7 release returns snapshot tenths", d, fmt(t0, 8));
        rd(8'h09, d); chk("R7 R8 live seconds after release", d, fmt(t, 9));
        rd(8'h0A, d); chk("R8 live minutes jumped", d, fmt(t, 10));
        rd(8'h08, d); chk("R7 live tenths", d, fmt(t, 8));

        // R3 exhaustive hour rollover sweep, both halves of the day
        for (int pm = 0; pm < 2; pm++) begin
            for (int h = 1; h <= 12; h++) begin
                load(pm, h, 59, 59, 9);
                ticks(1);
                read_all("R3 hour rollover");
            end
        end
        load(0, 12, 0, 59, 9); ticks(1); read_all("R2 minute carry");
        load(1, 5, 9, 9, 9);   ticks(1); read_all("R2 digit carry");

        // R10 halt on hours write, resume on tenths write
        load(0, 6, 20, 30, 4);
        wr(8'h0B, 8'h83);
        ticks(50);
        rd(8'h09, d); chk("R10 halted seconds", d, fmt(t, 9));
        rd(8'h0A, d); chk("R10 halted minutes", d, fmt(t, 10));
        rd(8'h0B, d); chk("R10 loaded hours", d, 8'h83);
        rd(8'h08, d); chk("R10 halted tenths", d, fmt(t, 8));
        wr(8'h08, 8'h02);
        ticks(25);
        read_all("R10 resumed");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule